// File: doc/BRIEF.md
# Locked Configuration Port with Key Entry

This block is the device-side configuration front end of a legacy I/O controller. The host sees two byte-wide ports: an index port (offset 0) and a data port (offset 1). The host writes a register number to the index port. It then reads or writes that register through the data port. After reset the interface is locked. Data accesses have no effect until the entry key byte has been written to the index port on two consecutive index writes. A distinct exit byte written to the index port locks the interface again.

The block holds a small set of registers of its own:

- read-only identification registers for manufacturer, device and revision;
- a logical-device select register, which drives a bank-select output.

Accesses to any other index go to the logical devices behind the block. They use a register address, write data, write strobe, read strobe and read data interface. Host reads return data one cycle after the read strobe.

Top module: `cfgp_port`

## Requirements
- R1: After reset the interface is locked (cfg_open = 0), the index register is 0x00, bank_sel is 0x00, and a read of either port returns 0xFF.
- R2: Writing the entry key 0x87 to the index port on two consecutive index writes sets cfg_open to 1 after the second write. Neither key byte is stored as the index.
- R3: If a single 0x87 is followed by any other index-port byte, the entry sequence restarts and the interface stays locked. The sequence 0x87, 0x12, 0x87 leaves it locked, and one more 0x87 then opens it.
- R4: While open, writing 0xAA to the index port clears cfg_open. The byte 0xAA is not stored as the index.
- R5: While locked, data-port reads return 0xFF, data-port writes change nothing and raise no dev_we, and index-port writes leave the index register unchanged.
- R6: While open, index 0x20 reads the device ID high byte and 0x21 the low byte (default 0x07A3). Index 0x22 reads the revision (default 0x12). Index 0x23 reads manufacturer ID high byte 0x19 and 0x24 the low byte 0x34. Writes to these five indices are ignored and raise no dev_we.
- R7: While open, a data write to index 0x07 loads bank_sel on the next cycle, and a data read of index 0x07 returns that value.
- R8: While open, a data access to any index other than 0x07 and 0x20 to 0x24 is forwarded in the same cycle. A write raises dev_we with dev_addr equal to the index and dev_wdata equal to the host byte. A read raises dev_re and returns dev_rdata.
- R9: Every host read produces exactly one host_rvalid pulse, in the cycle after host_rd.
- R10: While open, a read of the index port returns the current index register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_port | input | 1 | 0 = index port, 1 = data port |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read result |
| host_rvalid | output | 1 | Read result valid, one cycle after host_rd |
| cfg_open | output | 1 | Configuration access unlocked |
| bank_sel | output | 8 | Logical-device select value |
| dev_addr | output | 8 | Register index toward the logical devices |
| dev_wdata | output | 8 | Write data toward the logical devices |
| dev_we | output | 1 | Forwarded write strobe |
| dev_re | output | 1 | Forwarded read strobe |
| dev_rdata | input | 8 | Read data from the logical devices, valid in the dev_re cycle |

## Verification
The assertions assume that host_wr and host_rd are never high in the same cycle. They also assume that dev_rdata is valid combinationally in the cycle dev_re is high. The bench drives one strobe at a time, one cycle long, on the falling edge. It returns dev_rdata as a fixed function of dev_addr, so the forwarded read path stays within those assumptions.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    typedef enum logic [1:0] {
        LK_IDLE = 2'd0,
        LK_HALF = 2'd1,
        LK_OPEN = 2'd2
    } lock_state_e;

    typedef struct packed {
        lock_state_e st;
    } fsm_regs_t;

    typedef struct packed {
        logic [7:0] index;
        logic [7:0] bank;
        logic [7:0] rdata;
        logic       rvalid;
    } rf_regs_t;

endpackage

// File: rtl/cfgp_unlock_fsm.sv
module cfgp_unlock_fsm
    import cfgp_pkg::*;
#(
    parameter int          DW        = 8,
    parameter logic [DW-1:0] KEY_ENTER = 8'h87,
    parameter logic [DW-1:0] KEY_EXIT  = 8'hAA
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idx_wr,
    input  logic [DW-1:0] wdata,
    output logic          cfg_open,
    output logic          idx_load
);

    fsm_regs_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        idx_load = 1'b0;
        if (idx_wr) begin
            unique case (r_q.st)
                LK_IDLE: if (wdata == KEY_ENTER) r_d.st = LK_HALF;
                LK_HALF: r_d.st = (wdata == KEY_ENTER) ? LK_OPEN : LK_IDLE;
                LK_OPEN: begin
                    if (wdata == KEY_EXIT) r_d.st = LK_IDLE;
                    else                   idx_load = 1'b1;
                end
                default: r_d.st = LK_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q.st <= LK_IDLE;
        else        r_q <= r_d;
    end

    assign cfg_open = (r_q.st == LK_OPEN);

    // R2
    open_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> $past(idx_wr && wdata == KEY_ENTER));

    // R3
    bad_second_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == LK_HALF && idx_wr && wdata != KEY_ENTER) |=> !cfg_open);

    // R4
    exit_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && idx_wr && wdata == KEY_EXIT) |=> !cfg_open);

endmodule

// File: rtl/cfgp_regfile.sv
module cfgp_regfile
    import cfgp_pkg::*;
#(
    parameter int          DW        = 8,
    parameter logic [DW-1:0] LDSEL_IDX = 8'h07,
    parameter logic [DW-1:0] ID_BASE   = 8'h20,
    parameter logic [15:0] DEV_ID    = 16'h07A3,
    parameter logic [DW-1:0] DEV_REV   = 8'h12,
    parameter logic [15:0] MFG_ID    = 16'h1934
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_open,
    input  logic          idx_load,
    input  logic          data_wr,
    input  logic          data_rd,
    input  logic          idx_rd,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] dev_rdata,
    output logic [DW-1:0] index,
    output logic [DW-1:0] bank_sel,
    output logic [DW-1:0] rdata,
    output logic          rvalid,
    output logic          dev_we,
    output logic          dev_re
);

    localparam int NUM_ID = 5;

    rf_regs_t r_q, r_d;

    logic [DW-1:0] id_val [NUM_ID];
    logic          hit_id;
    logic          hit_ld;
    logic [DW-1:0] id_rd;

    assign id_val[0] = DEV_ID[15:8];
    assign id_val[1] = DEV_ID[7:0];
    assign id_val[2] = DEV_REV;
    assign id_val[3] = MFG_ID[15:8];
    assign id_val[4] = MFG_ID[7:0];

    always_comb begin
        hit_id = 1'b0;
        id_rd  = '0;
        for (int i = 0; i < NUM_ID; i++) begin
            if (r_q.index == ID_BASE + DW'(i)) begin
                hit_id = 1'b1;
                id_rd  = id_val[i];
            end
        end
    end

    assign hit_ld = (r_q.index == LDSEL_IDX);

    always_comb begin
        r_d        = r_q;
        r_d.rvalid = data_rd | idx_rd;
        dev_we     = 1'b0;
        dev_re     = 1'b0;
        if (idx_load) r_d.index = wdata;
        if (cfg_open && data_wr) begin
            if (hit_ld)       r_d.bank = wdata;
            else if (!hit_id) dev_we   = 1'b1;
        end
        if (data_rd || idx_rd) begin
            if (!cfg_open)    r_d.rdata = '1;
            else if (idx_rd)  r_d.rdata = r_q.index;
            else if (hit_ld)  r_d.rdata = r_q.bank;
            else if (hit_id)  r_d.rdata = id_rd;
            else begin
                dev_re    = 1'b1;
                r_d.rdata = dev_rdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.index  <= '0;
            r_q.bank   <= '0;
            r_q.rdata  <= '1;
            r_q.rvalid <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign index    = r_q.index;
    assign bank_sel = r_q.bank;
    assign rdata    = r_q.rdata;
    assign rvalid   = r_q.rvalid;

    // R5
    locked_bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open |=> $stable(bank_sel) && $stable(index));

    // R5
    locked_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open |-> !dev_we && !dev_re);

    // R7
    bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && data_wr && index == LDSEL_IDX) |=> bank_sel == $past(wdata));

    // R9
    rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd || idx_rd) |=> rvalid);

    // R9
    rvalid_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_rd || idx_rd) |=> !rvalid);

endmodule

// File: rtl/cfgp_port.sv
module cfgp_port
    import cfgp_pkg::*;
#(
    parameter int          DW        = 8,
    parameter logic [DW-1:0] KEY_ENTER = 8'h87,
    parameter logic [DW-1:0] KEY_EXIT  = 8'hAA,
    parameter logic [DW-1:0] LDSEL_IDX = 8'h07,
    parameter logic [DW-1:0] ID_BASE   = 8'h20,
    parameter logic [15:0] DEV_ID    = 16'h07A3,
    parameter logic [DW-1:0] DEV_REV   = 8'h12,
    parameter logic [15:0] MFG_ID    = 16'h1934
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic          host_port,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          host_rvalid,
    output logic          cfg_open,
    output logic [DW-1:0] bank_sel,
    output logic [DW-1:0] dev_addr,
    output logic [DW-1:0] dev_wdata,
    output logic          dev_we,
    output logic          dev_re,
    input  logic [DW-1:0] dev_rdata
);

    logic idx_wr, idx_rd, data_wr, data_rd, idx_load;

    assign idx_wr  = host_wr & ~host_port;
    assign idx_rd  = host_rd & ~host_port;
    assign data_wr = host_wr &  host_port;
    assign data_rd = host_rd &  host_port;

    cfgp_unlock_fsm #(
        .DW(DW), .KEY_ENTER(KEY_ENTER), .KEY_EXIT(KEY_EXIT)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr),
        .wdata    (host_wdata),
        .cfg_open (cfg_open),
        .idx_load (idx_load)
    );

    cfgp_regfile #(
        .DW(DW), .LDSEL_IDX(LDSEL_IDX), .ID_BASE(ID_BASE),
        .DEV_ID(DEV_ID), .DEV_REV(DEV_REV), .MFG_ID(MFG_ID)
    ) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_open  (cfg_open),
        .idx_load  (idx_load),
        .data_wr   (data_wr),
        .data_rd   (data_rd),
        .idx_rd    (idx_rd),
        .wdata     (host_wdata),
        .dev_rdata (dev_rdata),
        .index     (dev_addr),
        .bank_sel  (bank_sel),
        .rdata     (host_rdata),
        .rvalid    (host_rvalid),
        .dev_we    (dev_we),
        .dev_re    (dev_re)
    );

    assign dev_wdata = host_wdata;

    // R9
    no_rw_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_rd));

endmodule

// File: tb/cfgp_port_bench.sv
module cfgp_port_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0, host_port = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata, bank_sel, dev_addr, dev_wdata, dev_rdata;
    logic       host_rvalid, cfg_open, dev_we, dev_re;

    int checks = 0;
    int errors = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    assign dev_rdata = dev_addr ^ 8'h5A;

    cfgp_port u_cfgp_port (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_port(host_port), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .cfg_open(cfg_open), .bank_sel(bank_sel),
        .dev_addr(dev_addr), .dev_wdata(dev_wdata), .dev_we(dev_we),
        .dev_re(dev_re), .dev_rdata(dev_rdata)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr_index(input logic [7:0] b);
        @(negedge clk);
        host_wr = 1'b1; host_port = 1'b0; host_wdata = b;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic wr_data(input logic [7:0] b, input logic exp_we,
                           input logic [7:0] exp_addr, input string tag);
        @(negedge clk);
        host_wr = 1'b1; host_port = 1'b1; host_wdata = b;
        #1;
        check(tag, {7'd0, dev_we}, {7'd0, exp_we});
        if (exp_we) begin
            check(tag, dev_addr, exp_addr);
            check(tag, dev_wdata, b);
        end
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic port, input logic [7:0] exp, input string tag);
        @(negedge clk);
        host_rd = 1'b1; host_port = port;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    always @(negedge clk) begin
        if (host_rvalid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R9 actual rvalid 1 expected 0 (no pending read)");
            end else begin
                check(tag_q.pop_front(), host_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R9 actual %0d pending reads expected 0", exp_q.size());
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 open", {7'd0, cfg_open}, 8'h00);
        check("R1 bank", bank_sel, 8'h00);
        check("R1 index", dev_addr, 8'h00);
        rd(1'b1, 8'hFF, "R1 data read");
        rd(1'b0, 8'hFF, "R1 index read");

        // R5 locked writes ignored
        wr_index(8'h07);
        wr_data(8'h55, 1'b0, 8'h00, "R5 locked no dev_we");
        check("R5 locked bank", bank_sel, 8'h00);
        check("R5 locked index", dev_addr, 8'h00);

        // R3 broken sequence
        wr_index(8'h87);
        wr_index(8'h12);
        wr_index(8'h87);
        check("R3 still locked", {7'd0, cfg_open}, 8'h00);
        rd(1'b1, 8'hFF, "R3 locked read");
        // R2 second consecutive key opens
        wr_index(8'h87);
        check("R2 open", {7'd0, cfg_open}, 8'h01);
        rd(1'b0, 8'h00, "R2 keys not stored as index");

        // R6 identification
        wr_index(8'h20); rd(1'b1, 8'h07, "R6 dev hi");
        wr_index(8'h21); rd(1'b1, 8'hA3, "R6 dev lo");
        wr_index(8'h22); rd(1'b1, 8'h12, "R6 rev");
        wr_index(8'h23); rd(1'b1, 8'h19, "R6 mfg hi");
        wr_data(8'hFF, 1'b0, 8'h00, "R6 id write no dev_we");
        rd(1'b1, 8'h19, "R6 mfg hi after write");
        wr_index(8'h24); rd(1'b1, 8'h34, "R6 mfg lo");

        // R7 logical device select
        wr_index(8'h07);
        wr_data(8'h06, 1'b0, 8'h00, "R7 ldsel no dev_we");
        check("R7 bank_sel", bank_sel, 8'h06);
        rd(1'b1, 8'h06, "R7 readback");
        // R10 index readback
        rd(1'b0, 8'h07, "R10 index read");

        // R8 forwarding
        wr_index(8'h40);
        wr_data(8'hC3, 1'b1, 8'h40, "R8 forward write");
        @(negedge clk);
        host_rd = 1'b1; host_port = 1'b1;
        exp_q.push_back(8'h1A); tag_q.push_back("R8 forward read");
        #1;
        check("R8 dev_re", {7'd0, dev_re}, 8'h01);
        @(negedge clk);
        host_rd = 1'b0;

        // R4 exit key
        wr_index(8'hAA);
        check("R4 locked", {7'd0, cfg_open}, 8'h00);
        rd(1'b1, 8'hFF, "R4 locked read");
        wr_index(8'h07);
        wr_data(8'h03, 1'b0, 8'h00, "R5 locked no dev_we again");
        check("R5 bank held", bank_sel, 8'h06);
        wr_index(8'h87);
        wr_index(8'h87);
        check("R2 reopen", {7'd0, cfg_open}, 8'h01);
        rd(1'b0, 8'h40, "R4 exit byte not stored");
        rd(1'b1, 8'h1A, "R8 read after reopen");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule